// File: doc/BRIEF.md
# Sprite Page Copy Engine

The engine watches every write the CPU issues. A write to the trigger address 0x4014 starts a copy. The byte written in that write names a 256-byte source page. The engine then masters the memory bus: it reads each byte of that page in ascending order and writes each one to the fixed sprite-attribute data port at 0x2004. The CPU is held off for the whole copy. When the last byte has been written, the engine raises a single-cycle completion pulse.

Each byte takes exactly two clock cycles, a read cycle followed by a write cycle, so every copy lasts a fixed 512 cycles. A write to the trigger address is consumed by the engine and is never passed on to ordinary memory. All other CPU writes are passed on as usual.

Top module: `sprdma_engine`

## Requirements
- R1: A snooped write (`cpu_we`=1) to address 0x4014 while idle starts a copy. `busy` and `cpu_stall` are 1 from the first clock edge after that write.
- R2: The read cycles present source addresses `{H, k}` for k = 0 to 255 in ascending order, where H is the byte written with the trigger.
- R3: Every write cycle drives `mem_addr` = 0x2004 and `mem_wdata` = the byte returned in the read cycle just before it.
- R4: Read and write cycles alternate, starting with a read. Exactly one of `mem_rd` and `mem_wr` is 1 in each busy cycle. Read data is sampled at the end of the read cycle in which `mem_rd` is 1.
- R5: `busy` and `cpu_stall` stay 1 for exactly 512 consecutive cycles per copy.
- R6: A trigger write that arrives while `busy` is 1 is ignored. The source page and the sequence of the running copy do not change.
- R7: In the cycle after the 256th write cycle, `busy` and `cpu_stall` are 0 and `done` is 1 for that one cycle only.
- R8: The source offset never carries into the page number. A copy of page 0xFF ends at source address 0xFFFF.
- R9: `cpu_wr_fwd` equals `cpu_we` for every address except 0x4014, and it is 0 for a write to 0x4014.
- R10: After reset, `busy`, `cpu_stall`, `done`, `mem_rd` and `mem_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Address of the snooped CPU write |
| cpu_wdata | input | 8 | Data of the snooped CPU write |
| cpu_we | input | 1 | Write strobe of the snooped CPU access |
| cpu_wr_fwd | output | 1 | Write strobe passed on to ordinary memory |
| mem_addr | output | 16 | Master bus address |
| mem_rdata | input | 8 | Master bus read data, valid in the read cycle |
| mem_wdata | output | 8 | Master bus write data |
| mem_rd | output | 1 | Master read strobe |
| mem_wr | output | 1 | Master write strobe |
| cpu_stall | output | 1 | Holds the CPU off while the copy runs |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench copies the two edge pages, 0x00 and 0xFF, and several random pages. Page 0xFF matters because an offset counter that carried into the page number would step into page 0x00, and the run would either read the wrong bytes or end at the wrong address. While a copy is running, the bench issues a second trigger with a different page. A design that accepted it would switch source page or restart its count, and either the address stream or the 512-cycle length would be off. Each cycle is checked for strobe order, and each byte is checked against the source pattern. An off-by-one in the end condition would show up as a run of 510 or 514 cycles, or as a misplaced `done`. Writes to the trigger address and to other addresses are checked for forwarding.

// File: rtl/sprdma_pkg.sv
package sprdma_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 8;
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int RUN_CYC = 2 * (1 << OFF_W);
    localparam int CNT_W   = $clog2(RUN_CYC) + 1;
    localparam logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014;
    localparam logic [ADDR_W-1:0] PORT_ADDR = 16'h2004;

    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } src_addr_t;

    function automatic logic [ADDR_W-1:0] src_flat(input src_addr_t s);
        return {s.page, s.off};
    endfunction
endpackage

// File: rtl/sprdma_snoop.sv
module sprdma_snoop
    import sprdma_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              busy,
    output logic              start,
    output logic              fwd
);
    logic hit;

    always_comb begin
        hit   = cpu_we && (cpu_addr == TRIG_ADDR);
        start = hit && !busy;
        fwd   = cpu_we && !hit;
    end
endmodule

// File: rtl/sprdma_addrgen.sv
module sprdma_addrgen
    import sprdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              step,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata,
    output src_addr_t         src,
    output logic              last,
    output logic [DATA_W-1:0] hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            hold <= '0;
        end else begin
            if (load) begin
                src.page <= page_in;
                src.off  <= '0;
            end else if (step) begin
                src.off <= src.off + 1'b1;
            end
            if (capture)
                hold <= rdata;
        end
    end

    assign last = &src.off;

    AST_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !last |=> src.off == $past(src.off) + 1'b1); // R2
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(src.page)); // R8
    AST_HOLD_CAPT: assert property (@(posedge clk) disable iff (rst)
        capture |=> hold == $past(rdata)); // R3
endmodule

// File: rtl/sprdma_seq.sv
module sprdma_seq
    import sprdma_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   last,
    output phase_t phase,
    output logic   done
);
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE:  if (start) phase <= PH_READ;
                PH_READ:  phase <= PH_WRITE;
                PH_WRITE: begin
                    if (last) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        phase <= PH_READ;
                    end
                end
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || phase == PH_IDLE) run_cnt <= '0;
        else                          run_cnt <= run_cnt + 1'b1;
    end

    AST_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
        done |-> run_cnt == CNT_W'(RUN_CYC)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE && start |=> phase == PH_READ); // R1
endmodule

// File: rtl/sprdma_engine.sv
module sprdma_engine
    import sprdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic              cpu_wr_fwd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              cpu_stall,
    output logic              busy,
    output logic              done
);
    phase_t            phase;
    logic              start;
    logic              last;
    src_addr_t         src;
    logic [DATA_W-1:0] hold;

    sprdma_snoop u_snoop (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .busy     (busy),
        .start    (start),
        .fwd      (cpu_wr_fwd)
    );

    sprdma_addrgen u_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .page_in (cpu_wdata[PAGE_W-1:0]),
        .step    (mem_wr),
        .capture (mem_rd),
        .rdata   (mem_rdata),
        .src     (src),
        .last    (last),
        .hold    (hold)
    );

    sprdma_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .phase (phase),
        .done  (done)
    );

    always_comb begin
        busy      = (phase != PH_IDLE);
        cpu_stall = busy;
        mem_rd    = (phase == PH_READ);
        mem_wr    = (phase == PH_WRITE);
        mem_addr  = mem_wr ? PORT_ADDR : src_flat(src);
        mem_wdata = hold;
    end

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        busy |-> $countones({mem_rd, mem_wr}) == 1); // R4
    AST_BUSY_TRIG: assert property (@(posedge clk) disable iff (rst)
        busy && cpu_we && cpu_addr == TRIG_ADDR |=> $stable(src.page)); // R6
    AST_PORT_DEST: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr == PORT_ADDR && mem_wdata == $past(mem_rdata)); // R3
endmodule

// File: tb/sprdma_engine_test.sv
module sprdma_engine_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_we;
    logic        cpu_wr_fwd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, cpu_stall, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sprdma_engine uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_wr_fwd(cpu_wr_fwd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .cpu_stall(cpu_stall), .busy(busy), .done(done)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] + a[15:8] * 8'd7) ^ 8'h3c;
    endfunction

    always_comb mem_rdata = pat(mem_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_copy(input logic [7:0] h, input bit inject);
        @(negedge clk);
        cpu_addr = 16'h4014; cpu_wdata = h; cpu_we = 1'b1;
        #1 check(cpu_wr_fwd == 1'b0, "R9 trigger write forwarded", 32'(cpu_wr_fwd), 0);
        for (int cyc = 1; cyc <= 512; cyc++) begin
            @(negedge clk);
            cpu_we = 1'b0;
            if (inject && cyc == 101) begin
                cpu_addr = 16'h4014; cpu_wdata = h ^ 8'h55; cpu_we = 1'b1;
            end
            #1;
            if (cyc % 2 == 1) begin
                logic [15:0] ea;
                ea = {h, 8'((cyc - 1) / 2)};
                check(busy && cpu_stall && mem_rd && !mem_wr && mem_addr == ea,
                      "R2 R4 R6 read cycle", {busy, cpu_stall, mem_rd, mem_wr, 12'h0, mem_addr},
                      {4'b1110, 12'h0, ea});
                if (cyc == 511 && h == 8'hff)
                    check(mem_addr == 16'hffff, "R8 last source address", 32'(mem_addr), 32'hffff);
            end else begin
                logic [7:0] ed;
                ed = pat({h, 8'((cyc - 2) / 2)});
                check(busy && cpu_stall && mem_wr && !mem_rd && mem_addr == 16'h2004 && mem_wdata == ed,
                      "R3 R5 write cycle", {busy, cpu_stall, mem_rd, mem_wr, 4'h0, mem_wdata, mem_addr},
                      {4'b1101, 4'h0, ed, 16'h2004});
            end
            if (cyc == 1)
                check(busy && cpu_stall, "R1 busy after trigger", 32'({busy, cpu_stall}), 3);
        end
        @(negedge clk);
        cpu_we = 1'b0;
        #1 check(!busy && !cpu_stall && done && !mem_rd && !mem_wr, "R7 R5 end of run",
                 32'({busy, cpu_stall, done, mem_rd, mem_wr}), 32'b00100);
        @(negedge clk);
        #1 check(!done && !busy, "R7 done single cycle", 32'({done, busy}), 0);
    endtask

    initial begin
        cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; rst = 1'b1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 check(!busy && !cpu_stall && !done && !mem_rd && !mem_wr, "R10 reset state",
                 32'({busy, cpu_stall, done, mem_rd, mem_wr}), 0);
        @(negedge clk); rst = 1'b0;
        // R9 ordinary writes pass through
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cpu_addr = 16'($urandom_range(0, 16'h4013)); cpu_wdata = 8'($urandom); cpu_we = 1'b1;
            #1 check(cpu_wr_fwd == 1'b1 && !busy, "R9 ordinary write", 32'(cpu_wr_fwd), 1);
        end
        @(negedge clk); cpu_we = 1'b0;
        @(negedge clk);
        #1 check(!busy, "R9 ordinary write no start", 32'(busy), 0);
        run_copy(8'h00, 1'b0);
        run_copy(8'hff, 1'b0);
        run_copy(8'h3a, 1'b1);   // R6 retrigger mid-run
        for (int i = 0; i < 4; i++)
            run_copy(8'($urandom), (i % 2) == 1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule